// File: doc/BRIEF.md
# Rectangular Binary Erosion and Dilation Unit

This block filters a binary mask as it streams past, one bit per clock in raster order, with a rectangular structuring element of all ones. The element is se_w columns wide and se_h rows tall, both set at run time. A single input selects erosion or dilation. The block does not use a window of comparators. It splits the element into a horizontal pass and a vertical pass. The horizontal pass is a run counter that counts consecutive ones along the line. The vertical pass keeps one run counter per column in a line memory and counts consecutive horizontal hits down that column. Each pass outputs a 1 when its counter reaches the element size. The counter then reloads to size minus one, so a longer run keeps producing hits. Dilation reuses the same datapath: the input and the result are both inverted.

Each result is centred on the element. Any part of the window that lies outside the image is filled with padding. A scan controller inside the block supplies the padding at the west and north edges by presetting the counters. It supplies the padding at the east and south edges by inserting padding steps. During those steps it lowers `in_ready`, so that the last columns of every line and the last lines of the frame leave the block without waiting for more input. The block produces at most one result per clock.

Top module: `morph_rect`

## Requirements
- R1: `out_valid` is high for exactly one clock for each of the LINE_W x FRAME_H output pixels of a frame. Results come in raster order, one clock after the scan step that completes their window. There is never more than one result per clock.
- R2: `in_ready` is high only at real pixel positions. After each line except the last, it stays low for se_w/2 clocks (the east padding). After the last pixel of a frame, the block steps through se_w/2 + (se_h/2)*(LINE_W + se_w/2) padding positions on its own, with no input.
- R3: `se_w`, `se_h` and `mode_dilate` are captured when the first pixel of a frame is accepted. Changing them later in the frame has no effect on that frame. A size of 0 is treated as 1. A size above MAX_W (or MAX_H) is treated as that maximum.
- R4: With `mode_dilate` = 0 (erosion), the output for pixel (cx, cy) is 1 only when every pixel is 1 in columns cx-(se_w-1)/2 .. cx+se_w/2 of rows cy-(se_h-1)/2 .. cy+se_h/2. Positions outside the image count as 1.
- R5: With `mode_dilate` = 1 (dilation), the output for pixel (cx, cy) is 1 when any pixel in the same window is 1. Positions outside the image count as 0.
- R6: A 1 x 1 element passes the mask through unchanged, in either mode.
- R7: The first result of a frame appears one clock after the pixel at column se_w/2 of line se_h/2 is accepted. With no input gaps, that pixel is accepted pixel number (se_h/2)*LINE_W + se_w/2 + 1.
- R8: A run of ones longer than the element keeps producing hits in both passes. An all-ones frame therefore erodes to all ones at any size, and an all-zeros frame dilates to all zeros.
- R9: While reset is held and just after it is released, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_dilate | input | 1 | 0 selects erosion, 1 selects dilation |
| se_w | input | clog2(MAX_W+1) | Element width in pixels |
| se_h | input | clog2(MAX_H+1) | Element height in lines |
| in_valid | input | 1 | A mask bit is presented |
| in_bit | input | 1 | Mask bit, raster order |
| in_ready | output | 1 | The scan is at a real pixel position and takes the presented bit |
| out_valid | output | 1 | A filtered bit is presented |
| out_bit | output | 1 | Filtered mask bit, raster order |

## Verification
The bench goes after the image borders, where each kind of padding matters. A design with the wrong padding value would erode the frame edge or grow a halo around it. Wrong counter presets would shift results by one column or one line near the top-left corner. Even element sizes are tested because their window is asymmetric, and swapping the two spans would shift the whole output by a pixel. Frames of all ones and all zeros, together with runs longer than the element, catch a counter that saturates or wraps instead of reloading. A configuration change in mid-frame, a zero size and an oversized size catch unlatched or unclamped settings. Counting `in_ready` gaps and tail cycles catches a flush that is too short, which drops the last columns, or too long, which stalls the next frame.

// File: rtl/morph_pkg.sv
package morph_pkg;

  localparam int SPAN_BITS = 8;
  typedef logic [SPAN_BITS-1:0] span_t;

  // Result of one run-counter step.
  typedef struct packed {
    span_t cnt;
    logic  hit;
  } run_t;

  // Legal element size: 0 becomes 1, anything above the ceiling becomes the ceiling.
  function automatic span_t fit_size(span_t req, span_t ceiling);
    if (req == '0) return span_t'(1);
    if (req > ceiling) return ceiling;
    return req;
  endfunction

  // Number of window positions before the centre.
  function automatic span_t lead_of(span_t size);
    return (size - span_t'(1)) >> 1;
  endfunction

  // Number of window positions after the centre.
  function automatic span_t trail_of(span_t size);
    return size >> 1;
  endfunction

  // One step of a run counter. A zero clears the run and a one extends it.
  // Reaching the limit gives a hit, and the counter reloads to limit-1.
  function automatic run_t run_advance(span_t prev, logic b, span_t limit);
    run_t  r;
    span_t grown;
    grown = b ? prev + span_t'(1) : '0;
    r.hit = (grown >= limit);
    r.cnt = r.hit ? limit - span_t'(1) : grown;
    return r;
  endfunction

endpackage

// File: rtl/morph_scan.sv
module morph_scan
  import morph_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int FRAME_H = 10,
  parameter int MAX_W   = 5,
  parameter int MAX_H   = 5,
  localparam int XW = $clog2(LINE_W + MAX_W / 2 + 1),
  localparam int YW = $clog2(FRAME_H + MAX_H / 2 + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  span_t         req_w,
  input  span_t         req_h,
  input  logic          req_dil,
  output logic          step,
  output logic          ready,
  output logic          pad_pos,
  output logic          west_edge,
  output logic          north_edge,
  output logic          col_ok,
  output logic          row_ok,
  output logic [XW-1:0] cx,
  output span_t         w_eff,
  output span_t         h_eff,
  output span_t         lead_w,
  output span_t         lead_h,
  output logic          dil_eff
);

  logic [XW-1:0] x_q;
  logic [YW-1:0] y_q;
  span_t         w_q, h_q;
  logic          dil_q;

  logic  origin;
  logic  last_x, last_y;
  span_t w_in, h_in, r_pad, b_pad;

  assign origin = (x_q == '0) && (y_q == '0);
  assign w_in   = fit_size(req_w, span_t'(MAX_W));
  assign h_in   = fit_size(req_h, span_t'(MAX_H));

  // At the frame origin, the settings on the inputs are the ones used.
  assign w_eff   = origin ? w_in : w_q;
  assign h_eff   = origin ? h_in : h_q;
  assign dil_eff = origin ? req_dil : dil_q;

  assign r_pad  = trail_of(w_eff);
  assign b_pad  = trail_of(h_eff);
  assign lead_w = lead_of(w_eff);
  assign lead_h = lead_of(h_eff);

  // Boundary events
  assign west_edge  = (x_q == '0);
  assign north_edge = (y_q == '0);
  assign pad_pos    = (x_q >= XW'(LINE_W)) || (y_q >= YW'(FRAME_H));
  assign ready      = !pad_pos;
  assign step       = pad_pos || in_valid;

  assign col_ok = (x_q >= XW'(r_pad));
  assign row_ok = (y_q >= YW'(b_pad));
  assign cx     = x_q - XW'(r_pad);

  assign last_x = (x_q == XW'(LINE_W - 1) + XW'(r_pad));
  assign last_y = (y_q == YW'(FRAME_H - 1) + YW'(b_pad));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      w_q   <= span_t'(1);
      h_q   <= span_t'(1);
      dil_q <= 1'b0;
    end else if (step) begin
      if (origin) begin
        w_q   <= w_in;
        h_q   <= h_in;
        dil_q <= req_dil;
      end
      if (last_x) begin
        x_q <= '0;
        y_q <= last_y ? '0 : y_q + YW'(1);
      end else begin
        x_q <= x_q + XW'(1);
      end
    end
  end

  // R2: a padding position moves the scan on without any input.
  a_r2_flush_advances: assert property (@(posedge clk) disable iff (!rst_n)
    pad_pos |=> (x_q != $past(x_q)) || (y_q != $past(y_q)));

  // R3: the captured settings stay the same away from the frame origin.
  a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !origin |=> $stable(w_q) && $stable(h_q) && $stable(dil_q));

  // R3: the captured sizes are always in the legal range.
  a_r3_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (w_q >= span_t'(1)) && (w_q <= span_t'(MAX_W)) &&
    (h_q >= span_t'(1)) && (h_q <= span_t'(MAX_H)));

endmodule

// File: rtl/morph_row_pass.sv
module morph_row_pass
  import morph_pkg::*;
#(
  parameter int MAX_W = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step,
  input  logic  west_edge,
  input  logic  bit_in,
  input  span_t size_w,
  input  span_t lead_w,
  output logic  hit
);

  span_t cnt_q;
  run_t  nx;
  logic  last_hit_q;

  // At the start of a line, the west padding supplies lead_w ones.
  always_comb nx = run_advance(west_edge ? lead_w : cnt_q, bit_in, size_w);
  assign hit = nx.hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      last_hit_q <= 1'b0;
    end else if (step) begin
      cnt_q      <= nx.cnt;
      last_hit_q <= nx.hit;
    end
  end

  // R8: once a run has reached the width, each further one is still a hit.
  a_r8_run_sustained: assert property (@(posedge clk) disable iff (!rst_n)
    (step && bit_in && !west_edge && last_hit_q) |-> hit);

  // R4: the reload keeps the stored run below the widest element.
  a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < span_t'(MAX_W));

endmodule

// File: rtl/morph_col_pass.sv
module morph_col_pass
  import morph_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int XW     = 5,
  localparam int AW    = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          col_ok,
  input  logic [XW-1:0] cx,
  input  logic          north_edge,
  input  logic          s1_hit,
  input  span_t         size_h,
  input  span_t         lead_h,
  output logic          hit
);

  span_t       cnt_mem [LINE_W];
  logic [AW-1:0] idx;
  span_t       stored;
  run_t        nx;

  assign idx    = cx[AW-1:0];
  assign stored = cnt_mem[idx];

  // On the first line, the north padding supplies lead_h ones.
  always_comb nx = run_advance(north_edge ? lead_h : stored, s1_hit, size_h);
  assign hit = nx.hit;

  // One read and one write of the column counter per step.
  always_ff @(posedge clk) begin
    if (step && col_ok) cnt_mem[idx] <= nx.cnt;
  end

  // R1: every column written has a place in the line memory.
  a_r1_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    col_ok |-> (cx < XW'(LINE_W)));

  // R8: a column sitting one short of the height completes on another hit.
  a_r8_column_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (step && col_ok && !north_edge && s1_hit && (stored == size_h - span_t'(1))) |-> hit);

endmodule

// File: rtl/morph_rect.sv
module morph_rect
  import morph_pkg::*;
#(
  parameter int LINE_W  = 16,
  parameter int FRAME_H = 10,
  parameter int MAX_W   = 5,
  parameter int MAX_H   = 5,
  localparam int WB = $clog2(MAX_W + 1),
  localparam int HB = $clog2(MAX_H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_dilate,
  input  logic [WB-1:0] se_w,
  input  logic [HB-1:0] se_h,
  input  logic          in_valid,
  input  logic          in_bit,
  output logic          in_ready,
  output logic          out_valid,
  output logic          out_bit
);

  localparam int XW = $clog2(LINE_W + MAX_W / 2 + 1);

  logic          step, pad_pos, west_edge, north_edge, col_ok, row_ok, dil_eff;
  logic [XW-1:0] cx;
  span_t         w_eff, h_eff, lead_w, lead_h;
  logic          pix_e, s1_hit, s2_hit;

  morph_scan #(
    .LINE_W (LINE_W),
    .FRAME_H(FRAME_H),
    .MAX_W  (MAX_W),
    .MAX_H  (MAX_H)
  ) i_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .req_w     (span_t'(se_w)),
    .req_h     (span_t'(se_h)),
    .req_dil   (mode_dilate),
    .step      (step),
    .ready     (in_ready),
    .pad_pos   (pad_pos),
    .west_edge (west_edge),
    .north_edge(north_edge),
    .col_ok    (col_ok),
    .row_ok    (row_ok),
    .cx        (cx),
    .w_eff     (w_eff),
    .h_eff     (h_eff),
    .lead_w    (lead_w),
    .lead_h    (lead_h),
    .dil_eff   (dil_eff)
  );

  // The padding is 1 in the erosion domain. Dilation inverts the data on the way in.
  assign pix_e = pad_pos ? 1'b1 : (in_bit ^ dil_eff);

  morph_row_pass #(
    .MAX_W(MAX_W)
  ) i_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .west_edge(west_edge),
    .bit_in   (pix_e),
    .size_w   (w_eff),
    .lead_w   (lead_w),
    .hit      (s1_hit)
  );

  morph_col_pass #(
    .LINE_W(LINE_W),
    .XW    (XW)
  ) i_col (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .col_ok    (col_ok),
    .cx        (cx),
    .north_edge(north_edge),
    .s1_hit    (s1_hit),
    .size_h    (h_eff),
    .lead_h    (lead_h),
    .hit       (s2_hit)
  );

  // The output is inverted back for dilation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= step && col_ok && row_ok;
      if (step) out_bit <= s2_hit ^ dil_eff;
    end
  end

  // R1: every result follows a scan step by one clock.
  a_r1_out_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(step));

endmodule

// File: tb/test_morph_rect.sv
module test_morph_rect;

  localparam int CLK_PERIOD = 10;
  localparam int LINE_W  = 16;
  localparam int FRAME_H = 10;
  localparam int MAX_W   = 5;
  localparam int MAX_H   = 5;
  localparam int NPIX    = LINE_W * FRAME_H;
  localparam int NVEC    = 9;

  // Fields per entry: dilate, width, height, density (out of 16)
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd0, 8'd3, 8'd3, 8'd12},
    {8'd1, 8'd3, 8'd3, 8'd3},
    {8'd0, 8'd5, 8'd3, 8'd13},
    {8'd1, 8'd2, 8'd4, 8'd4},
    {8'd0, 8'd1, 8'd5, 8'd11},
    {8'd1, 8'd5, 8'd1, 8'd2},
    {8'd0, 8'd4, 8'd4, 8'd14},
    {8'd1, 8'd5, 8'd5, 8'd3},
    {8'd0, 8'd2, 8'd2, 8'd10}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_dilate;
  logic [2:0] se_w, se_h;
  logic       in_valid, in_bit;
  logic       in_ready, out_valid, out_bit;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit img  [FRAME_H][LINE_W];
  bit expv [NPIX];

  always #(CLK_PERIOD / 2) clk = ~clk;

  morph_rect #(
    .LINE_W(LINE_W), .FRAME_H(FRAME_H), .MAX_W(MAX_W), .MAX_H(MAX_H)
  ) i_morph_rect (
    .clk(clk), .rst_n(rst_n), .mode_dilate(mode_dilate),
    .se_w(se_w), .se_h(se_h), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input string tag, input int got, input int want, input string what);
    n_vec++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, want);
    end
  endtask

  function automatic bit pattern(int seed, int dens, int x, int y);
    return ((seed * 7919 + y * 131 + x * 29 + x * y * 3 + (x ^ y) * 17) % 16) < dens;
  endfunction

  function automatic int fit(int v, int top);
    if (v == 0) return 1;
    if (v > top) return top;
    return v;
  endfunction

  // Window model: explicit scan of every offset with padding at the borders
  task automatic model(input bit dil, input int w, input int h);
    for (int cy = 0; cy < FRAME_H; cy++) begin
      for (int cx = 0; cx < LINE_W; cx++) begin
        bit acc;
        acc = !dil;
        for (int dy = -((h - 1) / 2); dy <= h / 2; dy++) begin
          for (int dx = -((w - 1) / 2); dx <= w / 2; dx++) begin
            int yy, xx;
            bit v;
            yy = cy + dy;
            xx = cx + dx;
            if (yy < 0 || yy >= FRAME_H || xx < 0 || xx >= LINE_W) v = !dil;
            else v = img[yy][xx];
            if (dil) acc = acc | v;
            else     acc = acc & v;
          end
        end
        expv[cy * LINE_W + cx] = acc;
      end
    end
  endtask

  task automatic run_frame(input bit dil, input int w, input int h, input int seed,
                           input int dens, input int alt, input string tag);
    int fw, fh, rp, bp;
    int sent, got, cyc, first_acc, low_pend, tail, extra;
    fw = fit(w, MAX_W);
    fh = fit(h, MAX_H);
    rp = fw / 2;
    bp = fh / 2;
    for (int y = 0; y < FRAME_H; y++)
      for (int x = 0; x < LINE_W; x++)
        img[y][x] = pattern(seed, dens, x, y);
    model(dil, fw, fh);
    mode_dilate = dil;
    se_w = w[2:0];
    se_h = h[2:0];
    sent = 0; got = 0; cyc = 0; first_acc = -1; low_pend = 0; tail = 0;
    while (got < NPIX && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (out_valid) begin
        if (first_acc < 0) first_acc = sent;
        chk(tag, out_bit, expv[got], $sformatf("pixel %0d", got));
        got++;
      end
      if (sent == NPIX) tail++;
      if (sent < NPIX) begin
        // R3: settings changed after the first pixel must not matter
        if (alt >= 0 && sent >= 1) begin
          se_w = alt[2:0];
          se_h = alt[2:0];
          mode_dilate = !dil;
        end
        if (in_ready) begin
          in_valid = 1'b1;
          in_bit = img[sent / LINE_W][sent % LINE_W];
          sent++;
        end else begin
          in_valid = 1'b0;
          low_pend++;
        end
      end else begin
        in_valid = 1'b0;
      end
    end
    chk("R1", got, NPIX, "results per frame");
    chk("R7", first_acc, bp * LINE_W + rp + 1, "pixels accepted before first result");
    chk("R2", low_pend, (FRAME_H - 1) * rp, "east padding stalls");
    chk("R2", tail, rp + bp * (LINE_W + rp) + 1, "flush clocks after last pixel");
    extra = 0;
    repeat (4) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    chk("R1", extra, 0, "results after frame end");
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_bit = 1'b0;
    mode_dilate = 1'b0;
    se_w = 3'd3;
    se_h = 3'd3;
    repeat (3) @(negedge clk);
    chk("R9", out_valid, 0, "out_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9", out_valid, 0, "out_valid after reset");
    chk("R9", in_ready, 1, "in_ready after reset");

    // Table walk: erosion frames check R4, dilation frames check R5
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i][24], int'(VEC[i][23:16]), int'(VEC[i][15:8]), i + 1,
                int'(VEC[i][7:0]), -1, VEC[i][24] ? "R5" : "R4");
    end

    // R6: identity element in both modes
    run_frame(1'b0, 1, 1, 21, 8, -1, "R6");
    run_frame(1'b1, 1, 1, 22, 8, -1, "R6");

    // R8: long runs in both passes
    run_frame(1'b0, 5, 5, 23, 16, -1, "R8");
    run_frame(1'b1, 5, 5, 24, 0, -1, "R8");

    // R3: zero size and oversized size are clamped
    run_frame(1'b0, 0, 7, 25, 13, -1, "R3");
    run_frame(1'b1, 7, 0, 26, 3, -1, "R3");

    // R3: mid-frame change of all settings is ignored
    run_frame(1'b0, 3, 3, 27, 12, 5, "R3");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule